// File: doc/BRIEF.md
# Device Bus Strobe Release Sequencer

This block closes out a device bus cycle. While a transaction is open it drives the chip select, and also the strobe that belongs to the direction. A write drives the byte write enables, the data-buffer output enable and the data-bus drive. A read drives the output enable. When the strobe ends, the write enables or the output enable drop at once. The chip select, the buffer enable and the data drive then stay up for programmable hold times of their own.

Two 3-bit hold settings are kept in a small register set. The data-hold setting counts cycles from the strobe drop until the buffer enable and the data drive are released. The select-hold setting counts cycles from the strobe drop until the chip select is released.

The two countdowns run independently of each other. Either one is cut short when the transaction's overall period expires, which is signalled on an input by the primary cycle counter outside this block. At that point every output is released on the same edge.

Top module: `dev_hold_seq`

## Requirements
- R1: Synchronous active-low reset leaves the data-hold setting at 7 and the select-hold setting at 3, and leaves every strobe, select, buffer and busy output low.
- R2: With `cfg_wr` high at a clock edge, both settings take the values on `cfg_wdh_wr` and `cfg_csh_wr`, and `cfg_wdh_rd` and `cfg_csh_rd` then return them.
- R3: A `txn_start` taken while `busy_o` is low raises `cs_o` on that edge. For a write (`txn_write`=1) it also raises `wr_en_o`, `buf_oe_o` and `data_drv_o`. For a read (`txn_write`=0) it raises `rd_en_o`.
- R4: `strobe_end` while a strobe is up drops `wr_en_o` or `rd_en_o` on that same edge.
- R5: `cs_o` falls N edges after the strobe-drop edge, where N is the select-hold setting. N=0 means it falls on the strobe-drop edge itself.
- R6: On a write, `buf_oe_o` and `data_drv_o` fall together M edges after the strobe-drop edge, where M is the data-hold setting. M=0 means they fall on the strobe-drop edge.
- R7: `period_done` during an open transaction releases every output on that edge, whatever the hold settings or the remaining count. If it coincides with `strobe_end`, the hold times are skipped entirely.
- R8: `buf_oe_o` and `data_drv_o` never rise during a read.
- R9: `busy_o` stays high until the select, the buffer enable and the strobes are all released. A `txn_start` while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for both hold settings |
| cfg_wdh_wr | input | HW | New data-hold value |
| cfg_csh_wr | input | HW | New select-hold value |
| cfg_wdh_rd | output | HW | Current data-hold value |
| cfg_csh_rd | output | HW | Current select-hold value |
| txn_start | input | 1 | Open a transaction (taken only while idle) |
| txn_write | input | 1 | Direction of the opened transaction, 1 = write |
| strobe_end | input | 1 | Drop the write enables or the output enable now |
| period_done | input | 1 | Overall read/write period has expired |
| wr_en_o | output | 1 | Byte write enable strobe, active high |
| rd_en_o | output | 1 | Output enable strobe, active high |
| cs_o | output | 1 | Chip select, active high |
| buf_oe_o | output | 1 | Data-buffer output enable, active high |
| data_drv_o | output | 1 | Data-bus drive enable, active high |
| busy_o | output | 1 | Transaction in progress |

## Verification
The bench builds the block with its default 3-bit hold width. This makes the full setting space of 8 by 8 values small enough to sweep completely, for both directions. Each pair of settings is run with no period expiry, and with an expiry on the strobe-drop edge and at one, three and five cycles after it. That covers every ordering of the two hold countdowns and the abort edge. The release edges expected for each output are worked out as the smaller of the setting and the abort offset.

// File: rtl/hold_seq_pkg.sv
// Shared constants and types for the device bus strobe release sequencer.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subsets.
package hold_seq_pkg;
    localparam int HOLD_W_DEF = 3;
    localparam int WDH_RST_DEF = 7;
    localparam int CSH_RST_DEF = 3;
    localparam int NUM_CH = 2;

    // Release channels: each owns one held output and one countdown.
    typedef enum logic [0:0] {
        CH_SEL = 1'b0,
        CH_BUF = 1'b1
    } hold_ch_e;
endpackage

// File: rtl/hold_cfg_regs.sv
// Holds the two hold-time settings.
// Loads both on a write strobe and reads them back unchanged.
// Assumes a synchronous active-low reset.
module hold_cfg_regs #(
    parameter int HW      = 3,
    parameter int WDH_RST = 7,
    parameter int CSH_RST = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [HW-1:0] wdh_in,
    input  logic [HW-1:0] csh_in,
    output logic [HW-1:0] wdh_q,
    output logic [HW-1:0] csh_q
);
    localparam logic [HW-1:0] WDH_INIT = HW'(WDH_RST);
    localparam logic [HW-1:0] CSH_INIT = HW'(CSH_RST);

    // Setting storage: reset defaults, replaced on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdh_q <= WDH_INIT;
            csh_q <= CSH_INIT;
        end else if (wr) begin
            wdh_q <= wdh_in;
            csh_q <= csh_in;
        end
    end
endmodule

// File: rtl/hold_release_ctr.sv
// One release channel: an output flop plus a countdown.
// The output is set on arm. On load it stays up for hold_val more edges,
// and a hold_val of zero drops it on the load edge. abort clears it at once.
// Assumes arm, load and abort are never asserted together except abort+load,
// where abort wins.
module hold_release_ctr #(
    parameter int HW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          load,
    input  logic [HW-1:0] hold_val,
    input  logic          tick,
    input  logic          abort,
    output logic          held
);
    logic [HW-1:0] cnt;

    // Channel state: arm, load countdown, count down, or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
            cnt  <= '0;
        end else if (abort) begin
            held <= 1'b0;
            cnt  <= '0;
        end else if (arm) begin
            held <= 1'b1;
            cnt  <= '0;
        end else if (load) begin
            held <= held && (hold_val != '0);
            cnt  <= hold_val;
        end else if (tick && held) begin
            cnt <= cnt - 1'b1;
            if (cnt == HW'(1)) begin
                held <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dev_hold_seq.sv
// Device bus strobe release sequencer.
// Drives select, strobes, buffer enable and data drive for one transaction.
// The select and the buffer enable are released by independent hold
// countdowns that start at the strobe drop. period_done releases all outputs.
// Assumes the primary cycle counter lives outside and pulses period_done.
module dev_hold_seq
    import hold_seq_pkg::*;
#(
    parameter int HW      = HOLD_W_DEF,
    parameter int WDH_RST = WDH_RST_DEF,
    parameter int CSH_RST = CSH_RST_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [HW-1:0] cfg_wdh_wr,
    input  logic [HW-1:0] cfg_csh_wr,
    output logic [HW-1:0] cfg_wdh_rd,
    output logic [HW-1:0] cfg_csh_rd,
    input  logic          txn_start,
    input  logic          txn_write,
    input  logic          strobe_end,
    input  logic          period_done,
    output logic          wr_en_o,
    output logic          rd_en_o,
    output logic          cs_o,
    output logic          buf_oe_o,
    output logic          data_drv_o,
    output logic          busy_o
);
    logic          we_q;
    logic          oe_q;
    logic          strobe_on;
    logic          accept;
    logic          abort;
    logic          load;
    logic [NUM_CH-1:0]  ch_arm;
    logic [NUM_CH-1:0]  ch_held;
    logic [HW-1:0] ch_val [NUM_CH];

    hold_cfg_regs #(
        .HW     (HW),
        .WDH_RST(WDH_RST),
        .CSH_RST(CSH_RST)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdh_in(cfg_wdh_wr),
        .csh_in(cfg_csh_wr),
        .wdh_q (cfg_wdh_rd),
        .csh_q (cfg_csh_rd)
    );

    // Control decode: accept only when idle, abort only when busy.
    always_comb begin
        strobe_on = we_q || oe_q;
        accept    = txn_start && !busy_o;
        abort     = period_done && busy_o;
        load      = strobe_end && strobe_on && !period_done;
        ch_arm[CH_SEL] = accept;
        ch_arm[CH_BUF] = accept && txn_write;
        ch_val[CH_SEL] = cfg_csh_rd;
        ch_val[CH_BUF] = cfg_wdh_rd;
    end

    // Direction strobes: raised on accept, dropped on strobe end or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= 1'b0;
            oe_q <= 1'b0;
        end else if (accept) begin
            we_q <= txn_write;
            oe_q <= !txn_write;
        end else if (strobe_end || period_done) begin
            we_q <= 1'b0;
            oe_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        hold_release_ctr #(.HW(HW)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .arm     (ch_arm[g]),
            .load    (load),
            .hold_val(ch_val[g]),
            .tick    (!strobe_on),
            .abort   (abort),
            .held    (ch_held[g])
        );
    end

    // Output mapping: buffer enable and data drive share one release.
    always_comb begin
        wr_en_o    = we_q;
        rd_en_o    = oe_q;
        cs_o       = ch_held[CH_SEL];
        buf_oe_o   = ch_held[CH_BUF];
        data_drv_o = ch_held[CH_BUF];
        busy_o     = strobe_on || (ch_held != '0);
    end
endmodule

// File: rtl/hold_seq_chk.sv
// Property checker for dev_hold_seq, attached with bind.
// Assumes the synchronous active-low reset of the checked block.
module hold_seq_chk #(
    parameter int HW      = 3,
    parameter int WDH_RST = 7,
    parameter int CSH_RST = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [HW-1:0] cfg_wdh_rd,
    input logic [HW-1:0] cfg_csh_rd,
    input logic          txn_start,
    input logic          strobe_end,
    input logic          period_done,
    input logic          wr_en_o,
    input logic          rd_en_o,
    input logic          cs_o,
    input logic          buf_oe_o,
    input logic          busy_o
);
    // R1
    reset_defaults_chk: assert property (@(posedge clk)
        !rst_n |=> (cfg_wdh_rd == HW'(WDH_RST)) && (cfg_csh_rd == HW'(CSH_RST))
                   && !cs_o && !busy_o);

    // R4
    strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o || rd_en_o) && strobe_end |=> !wr_en_o && !rd_en_o);

    // R7
    period_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_done && busy_o |=> !cs_o && !buf_oe_o && !wr_en_o && !rd_en_o);

    // R8
    read_no_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> !buf_oe_o && !wr_en_o);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !wr_en_o && !rd_en_o && txn_start |=> !wr_en_o && !rd_en_o);

    // R9
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_o || buf_oe_o) |-> busy_o);
endmodule

bind dev_hold_seq hold_seq_chk #(
    .HW     (HW),
    .WDH_RST(WDH_RST),
    .CSH_RST(CSH_RST)
) u_hold_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wdh_rd (cfg_wdh_rd),
    .cfg_csh_rd (cfg_csh_rd),
    .txn_start  (txn_start),
    .strobe_end (strobe_end),
    .period_done(period_done),
    .wr_en_o    (wr_en_o),
    .rd_en_o    (rd_en_o),
    .cs_o       (cs_o),
    .buf_oe_o   (buf_oe_o),
    .busy_o     (busy_o)
);

// File: tb/test_dev_hold_seq.sv
// Sweeps all hold settings, both directions and several abort offsets.
module test_dev_hold_seq;
    localparam int HW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [HW-1:0] cfg_wdh_wr = '0;
    logic [HW-1:0] cfg_csh_wr = '0;
    logic [HW-1:0] cfg_wdh_rd;
    logic [HW-1:0] cfg_csh_rd;
    logic          txn_start = 1'b0;
    logic          txn_write = 1'b0;
    logic          strobe_end = 1'b0;
    logic          period_done = 1'b0;
    logic          wr_en_o, rd_en_o, cs_o, buf_oe_o, data_drv_o, busy_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dev_hold_seq #(.HW(HW)) i_dev_hold_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
        .cfg_wdh_wr(cfg_wdh_wr), .cfg_csh_wr(cfg_csh_wr),
        .cfg_wdh_rd(cfg_wdh_rd), .cfg_csh_rd(cfg_csh_rd),
        .txn_start(txn_start), .txn_write(txn_write),
        .strobe_end(strobe_end), .period_done(period_done),
        .wr_en_o(wr_en_o), .rd_en_o(rd_en_o), .cs_o(cs_o),
        .buf_oe_o(buf_oe_o), .data_drv_o(data_drv_o), .busy_o(busy_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One transaction. ab < 0: no expiry; else expiry ab edges after strobe drop.
    task automatic run_txn(input bit wr, input int wdh, input int csh, input int ab);
        int lim_c, lim_b;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdh_wr = HW'(wdh); cfg_csh_wr = HW'(csh);
        @(negedge clk);
        cfg_wr = 1'b0;
        chk("R2", "wdh readback", int'(cfg_wdh_rd), wdh);
        chk("R2", "csh readback", int'(cfg_csh_rd), csh);
        chk("R9", "idle before start", int'(busy_o), 0);
        txn_start = 1'b1; txn_write = wr;
        @(negedge clk);
        txn_start = 1'b0;
        chk("R3", "cs on start", int'(cs_o), 1);
        chk("R3", "write enable on start", int'(wr_en_o), int'(wr));
        chk("R3", "read enable on start", int'(rd_en_o), int'(!wr));
        chk("R8", "buffer on start", int'(buf_oe_o), int'(wr));
        chk("R6", "drive on start", int'(data_drv_o), int'(wr));
        @(negedge clk);
        strobe_end = 1'b1;
        period_done = (ab == 0);
        @(negedge clk);
        strobe_end = 1'b0;
        period_done = 1'b0;
        lim_c = (ab >= 0 && ab < csh) ? ab : csh;
        lim_b = wr ? ((ab >= 0 && ab < wdh) ? ab : wdh) : 0;
        for (int j = 0; j < 10; j++) begin
            chk("R4", "write enable after drop", int'(wr_en_o), 0);
            chk("R4", "read enable after drop", int'(rd_en_o), 0);
            chk(ab >= 0 ? "R7" : "R5", "cs hold", int'(cs_o), int'(j < lim_c));
            chk(ab >= 0 ? "R7" : (wr ? "R6" : "R8"), "buffer hold",
                int'(buf_oe_o), int'(j < lim_b));
            chk("R6", "drive hold", int'(data_drv_o), int'(j < lim_b));
            chk("R9", "busy", int'(busy_o), int'(j < lim_c || j < lim_b));
            if (ab > 0 && j == ab - 1) period_done = 1'b1;
            if (j == 0 && (lim_c > 0 || lim_b > 0)) begin
                txn_start = 1'b1; txn_write = !wr;
            end
            @(negedge clk);
            period_done = 1'b0;
            txn_start = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "wdh reset", int'(cfg_wdh_rd), 7);
        chk("R1", "csh reset", int'(cfg_csh_rd), 3);
        chk("R1", "cs reset", int'(cs_o), 0);
        chk("R1", "busy reset", int'(busy_o), 0);
        chk("R1", "strobes reset", int'(wr_en_o) + int'(rd_en_o), 0);
        rst_n = 1'b1;
        for (int w = 0; w < 8; w++) begin
            for (int c = 0; c < 8; c++) begin
                for (int d = 0; d < 2; d++) begin
                    run_txn(d[0], w, c, -1);
                    run_txn(d[0], w, c, 0);
                    run_txn(d[0], w, c, 1);
                    run_txn(d[0], w, c, 3);
                    run_txn(d[0], w, c, 5);
                end
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule